// File: doc/BRIEF.md
# Seconds-rate square-wave divider

This block takes a single 1 MHz clock and produces an exact 1 Hz square wave with equal high and low times. It works in three stages, all clocked by the same input clock. The first is a small free-running prescaler that raises a one-cycle enable every `PRE_DIV` clocks (32 by default). The second is an up-counter of modulus `MAIN_DIV` (15,625 by default) that moves only on that enable. It finds its last state by ANDing just the bit positions that are 1 in `MAIN_DIV-1`, not by comparing every bit. The third is a toggle flop that flips whenever the main counter wraps, which halves the rate and makes the duty cycle exactly 50%.

No stage uses a ripple or derived clock; every stage is a clock enable on the one input clock. Alongside the square wave the block gives a one-cycle tick that is high during the input cycle that begins at each output transition, so downstream logic can use it as an enable. The sizes are parameters, so the same structure serves any ratio `2*PRE_DIV*MAIN_DIV`. With the defaults the ratio is 1,000,000.

Top module: `sec_pulse_divider`

## Requirements
- R1: At a clock edge where `rst` is high, the block clears the prescaler, the main counter, `sq_out` and `edge_tick` to 0.
- R2: The prescaler raises its enable for exactly one cycle out of every `PRE_DIV` input cycles, starting with the `PRE_DIV`-th cycle after reset is released.
- R3: The main counter holds its value in every cycle where the prescaler enable is low.
- R4: The main counter value always stays in the range 0 to `MAIN_DIV-1`.
- R5: The main counter detects its last state by ANDing only the bits that are 1 in `MAIN_DIV-1`. On an enable in that state it returns to 0; on any other enable it adds one.
- R6: `sq_out` changes level exactly once every `PRE_DIV*MAIN_DIV` input cycles. Its first rise is at the `PRE_DIV*MAIN_DIV`-th rising clock edge after reset is released, which is edge 500,000 with the defaults.
- R7: Every high interval and every low interval of `sq_out` lasts exactly `PRE_DIV*MAIN_DIV` input cycles, so the duty cycle is 50%.
- R8: `edge_tick` is 1 for exactly the one input cycle that starts at the edge where `sq_out` changes, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock (1 MHz in the default configuration) |
| rst | input | 1 | Synchronous reset, active high |
| sq_out | output | 1 | Divided square wave, 50% duty cycle |
| edge_tick | output | 1 | One-cycle pulse in the cycle that starts at each change of `sq_out` |

## Verification
Any wrong internal count shows up at the ports as a shifted transition on `sq_out`. A prescaler that skips a state, a main counter that holds on a cycle it should advance, or a terminal decode that picks the wrong bit set all move the first output rise away from cycle `PRE_DIV*MAIN_DIV`. That makes the first half period the earliest point at which such an error becomes visible. The bench uses small configurations so that this point comes within a few dozen cycles. One configuration has a power-of-two prescaler and one has a non-power-of-two prescaler, so both counter variants and a sparse terminal mask (binary 101) are covered. A level mismatch between the output register and the tick register shows up in the same cycle as the transition.

// File: rtl/sec_div_pkg.sv
package sec_div_pkg;

    // State of the final halving stage.
    typedef struct packed {
        logic level;
        logic tick;
    } out_state_t;

endpackage

// File: rtl/sparse_wrap_counter.sv
module sparse_wrap_counter #(
    parameter int unsigned MODULUS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic tc
);
    // MODULUS must be at least 2.
    localparam int unsigned W    = $clog2(MODULUS);
    localparam logic [W-1:0] TERM = W'(MODULUS - 1);
    localparam bit POW2 = ((MODULUS & (MODULUS - 1)) == 0);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       hit;

    // Counting up from 0, the first value that has all the ones of TERM is
    // TERM itself, so only those bit positions need to enter the AND (R5).
    assign hit = &(st_q.cnt | ~TERM);
    assign tc  = adv & hit;

    generate
        if (POW2) begin : g_wrap
            // Natural binary wrap, so no clear mux is needed.
            always_comb begin
                st_d = st_q;
                if (adv) st_d.cnt = st_q.cnt + W'(1);
            end
        end else begin : g_clear
            always_comb begin
                st_d = st_q;
                if (adv) st_d.cnt = hit ? '0 : st_q.cnt + W'(1);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R4: the count never leaves 0..MODULUS-1
    a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= TERM);

    // R3: no enable, no movement
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(st_q.cnt));

    // R5: terminal count is followed by zero
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        tc |=> (st_q.cnt == '0));

    // R5: enable below the terminal state adds one
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !hit) |=> (st_q.cnt == $past(st_q.cnt) + W'(1)));

    // R2: terminal pulse is a single cycle
    a_r2_single: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc);

endmodule

// File: rtl/half_rate_toggle.sv
module half_rate_toggle
    import sec_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flip,
    output logic level,
    output logic tick
);
    out_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = st_q.level ^ flip;
        st_d.tick  = flip;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level = st_q.level;
    assign tick  = st_q.tick;

    // R8: a wrap gives a level change together with a tick
    a_r8_tick_on_edge: assert property (@(posedge clk) disable iff (rst)
        flip |=> (tick && (level != $past(level))));

    // R6: with no wrap the level holds and no tick appears
    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        !flip |=> (!tick && $stable(level)));

endmodule

// File: rtl/sec_pulse_divider.sv
module sec_pulse_divider #(
    parameter int unsigned PRE_DIV  = 32,
    parameter int unsigned MAIN_DIV = 15625
) (
    input  logic clk,
    input  logic rst,
    output logic sq_out,
    output logic edge_tick
);
    logic pre_tc;
    logic main_tc;

    sparse_wrap_counter #(.MODULUS(PRE_DIV)) u_pre (
        .clk (clk),
        .rst (rst),
        .adv (1'b1),
        .tc  (pre_tc)
    );

    sparse_wrap_counter #(.MODULUS(MAIN_DIV)) u_main (
        .clk (clk),
        .rst (rst),
        .adv (pre_tc),
        .tc  (main_tc)
    );

    half_rate_toggle u_out (
        .clk   (clk),
        .rst   (rst),
        .flip  (main_tc),
        .level (sq_out),
        .tick  (edge_tick)
    );

    // R5: a main wrap only happens on a prescaler enable
    a_r5_wrap_gated: assert property (@(posedge clk) disable iff (rst)
        main_tc |-> pre_tc);

    // R1: reset leaves the outputs low
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> (!sq_out && !edge_tick));

endmodule

// File: tb/sec_pulse_divider_tb.sv
module sec_pulse_divider_tb;

    localparam int PA = 4;
    localparam int MA = 5;
    localparam int HA = PA * MA;
    localparam int PB = 3;
    localparam int MB = 6;   // terminal 5 = binary 101, sparse mask
    localparam int HB = PB * MB;

    logic clk = 1'b0;
    logic rst;
    logic out_a, tick_a, out_b, tick_b;

    always #4 clk = ~clk;

    sec_pulse_divider #(.PRE_DIV(PA), .MAIN_DIV(MA)) u_dut (
        .clk (clk), .rst (rst), .sq_out (out_a), .edge_tick (tick_a)
    );

    sec_pulse_divider #(.PRE_DIV(PB), .MAIN_DIV(MB)) u_dut_b (
        .clk (clk), .rst (rst), .sq_out (out_b), .edge_tick (tick_b)
    );

    int checks = 0;
    int fails  = 0;
    int k;
    logic prev_a, prev_b;
    int run_a, run_b;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, k);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(out_a == 1'b0,  "R1 sq_out A",    int'(out_a),  0);
        check(tick_a == 1'b0, "R1 edge_tick A", int'(tick_a), 0);
        check(out_b == 1'b0,  "R1 sq_out B",    int'(out_b),  0);
        check(tick_b == 1'b0, "R1 edge_tick B", int'(tick_b), 0);
        rst = 1'b0;
        k = 0;
        prev_a = 1'b0; prev_b = 1'b0;
        run_a = 1; run_b = 1;
    endtask

    task automatic step();
        int ea, eb;
        bit ta, tb;
        @(posedge clk);
        k++;
        @(negedge clk);
        // R2 R3 R4 R5 R6: level is set by edges counted since release
        ea = (k / HA) % 2;
        eb = (k / HB) % 2;
        ta = (k % HA) == 0;
        tb = (k % HB) == 0;
        check(int'(out_a) == ea, "R6 sq_out A", int'(out_a), ea);
        check(int'(out_b) == eb, "R6/R5 sq_out B", int'(out_b), eb);
        check(tick_a == ta, "R8 edge_tick A", int'(tick_a), int'(ta));
        check(tick_b == tb, "R8 edge_tick B", int'(tick_b), int'(tb));
        // R7: each completed interval lasts exactly one half period
        if (out_a != prev_a) begin
            check(run_a == HA, "R7 interval A", run_a, HA);
            run_a = 1;
        end else run_a++;
        if (out_b != prev_b) begin
            check(run_b == HB, "R7 interval B", run_b, HB);
            run_b = 1;
        end else run_b++;
        prev_a = out_a;
        prev_b = out_b;
    endtask

    initial begin
        rst = 1'b1;
        k = 0;
        do_reset();
        // Several full periods of both configurations (R2, R3, R4 via timing)
        for (int i = 0; i < 8 * HA; i++) step();
        // Reset in the middle of a high interval
        for (int i = 0; i < HA + 7; i++) step();
        do_reset();
        for (int i = 0; i < 6 * HB; i++) step();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule